// File: doc/BRIEF.md
# Audio Quiet-Channel Gate Controller

This block watches a stream of signed audio samples and decides when a channel has been quiet long enough to be gated. Each valid sample is reduced to its absolute value and compared against a linear magnitude chosen by a 5-bit level code. The codes are spaced 1.5 dB apart, from about −76.5 dBFS at code 0 up to −30 dBFS at code 31. A run of consecutive quiet samples equal to the hold length (a parameter, nominally a quarter second of samples) engages the gate. Any louder sample releases the gate at once.

A 2-bit action field picks what happens while the gate is engaged. The gain can be frozen. The digital output can be muted. The gain can be faded down by one step request every few samples until the gain stage reports that it sits at its minimum. The last action fades first and then mutes. The gain stage, the register bus and any level smoothing are outside the block. It only drives flags and step requests toward them.

Top module: `audio_squelch`

## Requirements
- R1: After reset (active-low `rst_n`), `gateActive`, `holdGain`, `digMute` and `fadeStep` are all 0.
- R2: While `gateEn` is 0 the gate never engages, whatever the samples, and all outputs stay 0.
- R3: The threshold for code c is T(31) = floor(2^(W-1)·2072/65536) and T(c) = floor(T(c+1)·55142/65536). A sample is quiet only when its absolute value is strictly less than T(code). A sample whose magnitude equals T(code) is loud.
- R4: The gate engages on the HOLD_SAMPLES-th consecutive quiet valid sample, and `gateActive` is 1 from the next cycle. Cycles with `smpValid` low neither count nor break the run.
- R5: A loud valid sample releases the gate. All outputs are 0 from the next cycle, and qualification starts again from zero.
- R6: With action 2'b00, an engaged gate drives `holdGain` = 1, `digMute` = 0 and no `fadeStep`.
- R7: With action 2'b01, an engaged gate drives `digMute` = 1.
- R8: With action 2'b10, an engaged gate emits a one-cycle `fadeStep` on every FADE_DIV-th valid sample taken while `gainAtMin` is 0, counting from gate entry. Samples taken with `gainAtMin` = 1 give no step. `digMute` stays 0.
- R9: With action 2'b11, the block fades as in R8. After the first valid sample taken with `gainAtMin` = 1, `digMute` becomes 1 in the next cycle and fading stops.
- R10: Any change of the action field or the level code while enabled releases the gate on the next cycle and restarts qualification.
- R11: The most negative sample value has magnitude 2^(W-1) and is always loud.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gateEn | input | 1 | Gate enable (0 = off) |
| gateType | input | 2 | Action: 00 freeze, 01 mute, 10 fade, 11 fade then mute |
| thrCode | input | 5 | Level code, 1.5 dB per step |
| smpValid | input | 1 | Sample strobe |
| smpData | input | W | Signed two's-complement sample |
| gainAtMin | input | 1 | Gain stage reports minimum gain |
| gateActive | output | 1 | Gate engaged |
| holdGain | output | 1 | Freeze-gain request |
| digMute | output | 1 | Digital mute request |
| fadeStep | output | 1 | One-cycle gain step-down request |

## Verification
The bench targets the off-by-one edges of the quiet run. The gate must engage on exactly the HOLD_SAMPLES-th sample, even when idle cycles are mixed into the run. A counter that is off by one, or that counts idle cycles, would engage one sample early or late. It also drives a sample exactly at the threshold and the most negative value. A non-strict compare, or a wrapped absolute value, would keep the gate shut on a loud signal. The fade cases check the step spacing, the silence once the gain reaches its minimum, and the one-sample-late mute for the fade-then-mute action. A mid-gate change of the level code must release the gate; a design that missed the change would stay gated on a stale threshold.

// File: rtl/squelch_pkg.sv
package squelch_pkg;

  typedef enum logic [1:0] {
    TY_HOLD     = 2'b00,
    TY_MUTE     = 2'b01,
    TY_FADE     = 2'b10,
    TY_FADEMUTE = 2'b11
  } gate_type_e;

  typedef enum logic [1:0] {
    ST_OPEN,
    ST_HOLD,
    ST_MUTE,
    ST_FADE
  } gate_st_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reloadHold;
    logic stepClear;
    logic stepRun;
  } dp_cmd_t;

  // linear magnitude of level code (R3): -30 dBFS at code 31, 1.5 dB per code below
  function automatic logic [63:0] thr_mag(input int code, input int w);
    logic [63:0] x;
    x = ((64'd1 << (w - 1)) * 64'd2072) >> 16;
    for (int i = 31; i > code; i--) begin
      x = (x * 64'd55142) >> 16;
    end
    return x;
  endfunction

endpackage

// File: rtl/squelch_dp.sv
module squelch_dp
  import squelch_pkg::*;
#(
  parameter int W            = 24,
  parameter int HOLD_SAMPLES = 12000,
  parameter int FADE_DIV     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smpValid,
  input  logic [W-1:0] smpData,
  input  logic [4:0]   thrCode,
  input  dp_cmd_t      cmd,
  output logic         sampleQuiet,
  output logic         holdDone,
  output logic         stepTick
);

  localparam int HCW = $clog2(HOLD_SAMPLES + 1);
  localparam int SCW = $clog2(FADE_DIV + 1);
  localparam int NCODES = 32;

  logic [W-1:0]   thrTab [NCODES];
  logic [W-1:0]   mag;
  logic [HCW-1:0] holdCnt;
  logic [SCW-1:0] stepCnt;

  // constant level table, one entry per code (R3)
  for (genvar g = 0; g < NCODES; g++) begin : g_thr
    localparam logic [63:0] TV = thr_mag(g, W);
    assign thrTab[g] = TV[W-1:0];
  end

  // magnitude of two's-complement sample; most negative maps to 2^(W-1) (R11)
  always_comb begin
    if (smpData[W-1]) mag = ~smpData + 1'b1;
    else              mag = smpData;
  end

  assign sampleQuiet = (mag < thrTab[thrCode]);
  assign holdDone    = smpValid & sampleQuiet & (holdCnt <= HCW'(1));
  assign stepTick    = (stepCnt == SCW'(FADE_DIV - 1));

  // quiet-run counter (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= HCW'(HOLD_SAMPLES);
    end else if (cmd.reloadHold) begin
      holdCnt <= HCW'(HOLD_SAMPLES);
    end else if (smpValid && sampleQuiet && holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // fade pacing counter (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt <= '0;
    end else if (cmd.stepClear) begin
      stepCnt <= '0;
    end else if (cmd.stepRun) begin
      stepCnt <= stepTick ? '0 : stepCnt + 1'b1;
    end
  end

endmodule

// File: rtl/squelch_ctl.sv
module squelch_ctl
  import squelch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gateEn,
  input  logic [1:0] gateType,
  input  logic [4:0] thrCode,
  input  logic       smpValid,
  input  logic       gainAtMin,
  input  logic       sampleQuiet,
  input  logic       holdDone,
  input  logic       stepTick,
  output dp_cmd_t    cmd,
  output logic       gateActive,
  output logic       holdGain,
  output logic       digMute,
  output logic       fadeStep
);

  gate_st_e   st, stNext;
  logic [6:0] cfgPrev;
  logic       cfgChg;
  logic       release_;
  logic       stepRun;

  assign cfgChg   = ({gateType, thrCode} != cfgPrev);
  // R2, R5, R10: any of these drops the gate
  assign release_ = !gateEn | cfgChg | (smpValid & !sampleQuiet);
  assign stepRun  = (st == ST_FADE) & smpValid & !gainAtMin & !release_;

  always_comb begin
    stNext = st;
    if (release_) begin
      stNext = ST_OPEN;
    end else begin
      unique case (st)
        ST_OPEN: begin
          if (holdDone) begin
            unique case (gateType)
              TY_HOLD:     stNext = ST_HOLD;
              TY_MUTE:     stNext = ST_MUTE;
              TY_FADE,
              TY_FADEMUTE: stNext = ST_FADE;
              default:     stNext = ST_OPEN;
            endcase
          end
        end
        ST_FADE: begin
          // R9: mute follows the first sample seen at minimum gain
          if (smpValid && gainAtMin && gateType == TY_FADEMUTE) stNext = ST_MUTE;
        end
        default: stNext = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OPEN;
      cfgPrev  <= '0;
      fadeStep <= 1'b0;
    end else begin
      st       <= stNext;
      cfgPrev  <= {gateType, thrCode};
      fadeStep <= stepRun & stepTick;
    end
  end

  always_comb begin
    cmd.reloadHold = release_;
    cmd.stepClear  = (st != ST_FADE) | release_;
    cmd.stepRun    = stepRun;
  end

  assign gateActive = (st != ST_OPEN);
  assign holdGain   = (st == ST_HOLD);
  assign digMute    = (st == ST_MUTE);

endmodule

// File: rtl/audio_squelch.sv
module audio_squelch
  import squelch_pkg::*;
#(
  parameter int W            = 24,
  parameter int HOLD_SAMPLES = 12000,
  parameter int FADE_DIV     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gateEn,
  input  logic [1:0]   gateType,
  input  logic [4:0]   thrCode,
  input  logic         smpValid,
  input  logic [W-1:0] smpData,
  input  logic         gainAtMin,
  output logic         gateActive,
  output logic         holdGain,
  output logic         digMute,
  output logic         fadeStep
);

  dp_cmd_t cmd;
  logic    sampleQuiet;
  logic    holdDone;
  logic    stepTick;

  squelch_dp #(
    .W(W), .HOLD_SAMPLES(HOLD_SAMPLES), .FADE_DIV(FADE_DIV)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .smpValid(smpValid), .smpData(smpData),
    .thrCode(thrCode), .cmd(cmd), .sampleQuiet(sampleQuiet),
    .holdDone(holdDone), .stepTick(stepTick)
  );

  squelch_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .gateEn(gateEn), .gateType(gateType),
    .thrCode(thrCode), .smpValid(smpValid), .gainAtMin(gainAtMin),
    .sampleQuiet(sampleQuiet), .holdDone(holdDone), .stepTick(stepTick),
    .cmd(cmd), .gateActive(gateActive), .holdGain(holdGain),
    .digMute(digMute), .fadeStep(fadeStep)
  );

endmodule

// File: rtl/squelch_chk.sv
module squelch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gateEn,
  input logic [1:0] gateType,
  input logic       smpValid,
  input logic       gainAtMin,
  input logic       sampleQuiet,
  input logic       gateActive,
  input logic       holdGain,
  input logic       digMute,
  input logic       fadeStep
);

  p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gateEn |=> !gateActive);

  p_gate_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gateActive |-> $past(gateEn));

  p_loud_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smpValid && !sampleQuiet) |=> !gateActive);

  p_hold_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    holdGain |-> ($past(gateType) == 2'b00 && !digMute && !fadeStep));

  p_mute_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    digMute |-> $past(gateType[0]));

  p_step_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fadeStep |-> $past(smpValid && !gainAtMin));

  p_cfg_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEn && !$stable(gateType)) |=> !gateActive);

endmodule

bind audio_squelch squelch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gateEn(gateEn), .gateType(gateType),
  .smpValid(smpValid), .gainAtMin(gainAtMin), .sampleQuiet(sampleQuiet),
  .gateActive(gateActive), .holdGain(holdGain), .digMute(digMute),
  .fadeStep(fadeStep)
);

// File: tb/audio_squelch_bench.sv
module audio_squelch_bench;

  localparam int W    = 16;
  localparam int HOLD = 8;
  localparam int NDIV = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gateEn = 1'b0;
  logic [1:0]   gateType = 2'b00;
  logic [4:0]   thrCode = 5'd0;
  logic         smpValid = 1'b0;
  logic [W-1:0] smpData = '0;
  logic         gainAtMin = 1'b0;
  logic         gateActive, holdGain, digMute, fadeStep;

  always #2 clk = ~clk;

  audio_squelch #(.W(W), .HOLD_SAMPLES(HOLD), .FADE_DIV(NDIV)) u_audio_squelch (
    .clk(clk), .rst_n(rst_n), .gateEn(gateEn), .gateType(gateType),
    .thrCode(thrCode), .smpValid(smpValid), .smpData(smpData),
    .gainAtMin(gainAtMin), .gateActive(gateActive), .holdGain(holdGain),
    .digMute(digMute), .fadeStep(fadeStep)
  );

  int    total = 0;
  int    fails = 0;
  bit    done = 0;
  string curReq = "R1";
  longint tbThr [32];

  // reference model state
  int mMode = 0;   // 0 open, 1 freeze, 2 mute, 3 fade
  int mRun = 0;
  int mStep = 0;
  bit mFade = 0;
  int prevType = 0;
  int prevThr = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint absval(input logic [W-1:0] v);
    longint s;
    s = longint'($signed(v));
    return (s < 0) ? -s : s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 0; mRun = 0; mStep = 0; mFade = 0; prevType = 0; prevThr = 0;
    end else begin
      bit quiet, rel;
      quiet = absval(smpData) < tbThr[thrCode];
      rel = !gateEn || (int'(gateType) != prevType) || (int'(thrCode) != prevThr)
            || (smpValid && !quiet);
      mFade = 0;
      if (rel) begin
        mMode = 0; mRun = 0; mStep = 0;
      end else if (mMode == 0) begin
        if (smpValid) begin
          mRun++;
          if (mRun >= HOLD) begin
            mMode = (gateType == 2'b00) ? 1 : (gateType == 2'b01) ? 2 : 3;
            mStep = 0;
          end
        end
      end else if (mMode == 3 && smpValid) begin
        if (gainAtMin) begin
          if (gateType == 2'b11) mMode = 2;
        end else begin
          mStep++;
          if (mStep == NDIV) begin
            mFade = 1; mStep = 0;
          end
        end
      end
      prevType = int'(gateType);
      prevThr  = int'(thrCode);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({curReq, " gateActive"}, int'(gateActive), int'(mMode != 0));
      chk({curReq, " holdGain"},   int'(holdGain),   int'(mMode == 1));
      chk({curReq, " digMute"},    int'(digMute),    int'(mMode == 2));
      chk({curReq, " fadeStep"},   int'(fadeStep),   int'(mFade));
    end
  end

  task automatic put(input int v, input bit vld, input bit amin);
    smpData   = v[W-1:0];
    smpValid  = vld;
    gainAtMin = amin;
    @(negedge clk);
  endtask

  task automatic qualify();
    for (int i = 0; i < HOLD; i++) put(10, 1, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    longint x;
    x = ((longint'(1) << (W - 1)) * 2072) >>> 16;
    tbThr[31] = x;
    for (int c = 30; c >= 0; c--) tbThr[c] = (tbThr[c+1] * 55142) >>> 16;
  end

  initial begin
    int steps;
    repeat (3) @(negedge clk);
    chk("R1 reset gateActive", int'(gateActive), 0);
    chk("R1 reset mute/hold/step", int'({holdGain, digMute, fadeStep}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    curReq = "R2";
    gateType = 2'b01; thrCode = 5'd20;
    for (int i = 0; i < 12; i++) put(10, 1, 0);
    chk("R2 disabled stays open", int'(gateActive), 0);

    curReq = "R4";
    gateEn = 1'b1; gateType = 2'b00;
    put(0, 0, 0);
    for (int i = 0; i < HOLD - 1; i++) begin
      put(10, 1, 0);
      put(0, 0, 0);
    end
    chk("R4 one sample short", int'(gateActive), 0);
    put(10, 1, 0);
    chk("R4 engaged on last sample", int'(gateActive), 1);
    curReq = "R6";
    chk("R6 freeze asserted", int'(holdGain), 1);
    steps = 0;
    for (int i = 0; i < 6; i++) begin put(10, 1, 0); steps += int'(fadeStep); end
    chk("R6 no steps", steps, 0);
    chk("R6 no mute", int'(digMute), 0);

    curReq = "R3";
    put(int'(tbThr[20]) - 1, 1, 0);
    chk("R3 just below stays gated", int'(gateActive), 1);
    put(-int'(tbThr[20]) + 1, 1, 0);
    chk("R3 negative just below stays gated", int'(gateActive), 1);
    put(int'(tbThr[20]), 1, 0);
    chk("R3 equal magnitude releases", int'(gateActive), 0);

    curReq = "R5";
    qualify();
    chk("R5 regated", int'(gateActive), 1);
    put(5000, 1, 0);
    chk("R5 loud releases", int'(gateActive), 0);
    for (int i = 0; i < HOLD - 1; i++) put(10, 1, 0);
    chk("R5 restart from zero", int'(gateActive), 0);
    put(10, 1, 0);

    curReq = "R11";
    chk("R11 gated before", int'(gateActive), 1);
    put(-32768, 1, 0);
    chk("R11 most negative is loud", int'(gateActive), 0);

    curReq = "R7";
    gateType = 2'b01;
    put(0, 0, 0);
    qualify();
    chk("R7 mute asserted", int'(digMute), 1);
    chk("R7 no freeze", int'(holdGain), 0);

    curReq = "R10";
    thrCode = 5'd21;
    put(0, 0, 0);
    chk("R10 code change releases", int'(gateActive), 0);
    for (int i = 0; i < HOLD - 1; i++) put(10, 1, 0);
    chk("R10 requalify not early", int'(gateActive), 0);
    put(10, 1, 0);
    chk("R10 requalify done", int'(gateActive), 1);

    curReq = "R8";
    gateType = 2'b10;
    put(0, 0, 0);
    qualify();
    steps = 0;
    for (int i = 0; i < 3 * NDIV; i++) begin put(10, 1, 0); steps += int'(fadeStep); end
    chk("R8 step count", steps, 3);
    steps = 0;
    for (int i = 0; i < 6; i++) begin put(10, 1, 1); steps += int'(fadeStep); end
    chk("R8 silent at minimum", steps, 0);
    chk("R8 never mutes", int'(digMute), 0);

    curReq = "R9";
    gateType = 2'b11;
    put(0, 0, 0);
    qualify();
    steps = 0;
    for (int i = 0; i < NDIV; i++) begin put(10, 1, 0); steps += int'(fadeStep); end
    chk("R9 fade step first", steps, 1);
    chk("R9 not muted yet", int'(digMute), 0);
    put(10, 1, 1);
    chk("R9 mute after minimum", int'(digMute), 1);
    steps = 0;
    for (int i = 0; i < 6; i++) begin put(10, 1, 0); steps += int'(fadeStep); end
    chk("R9 fading stopped", steps, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule